// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Unpacker

This block sits between an instruction fetch path and the issue logic of a processor whose instructions are 15 or 30 bits wide and packed into 60-bit memory words. Fetch hands it whole words through a ready/valid handshake. The block cuts each word into 15-bit parcels, starting with the most significant one. It works out each instruction's length from its leading two octal digits, and it presents one decoded instruction at a time on a second ready/valid handshake.

For each instruction the block reports the 6-bit operation code and the three 3-bit register selectors. It also reports the 18-bit constant that a long instruction carries, the 6-bit shift or mask count, a length flag and a coarse execution-class code. A separate flag marks the two idiom patterns used as no-ops. A long instruction may not straddle two words: if one would begin in the final parcel position, that position is dropped and the next word is requested. When a branch is taken, a restart pulse throws away whatever is left of the buffered word, and decoding resumes at the top parcel of the next word delivered.

Top module: `parcel_unpacker`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Parcels of an accepted word are issued from the most significant 15 bits downward. out_slot gives the starting position: 0 for bits 59:45, 1 for 44:30, 2 for 29:15 and 3 for 14:0.
- R3: An instruction whose opcode (top 6 bits of its first parcel, as two octal digits) is 01–07, 50–52, 60–62 or 70–72 is long (out_long=1) and consumes two parcels. Every other opcode is short and consumes one.
- R4: Fields of the first parcel: out_opcode = bits 14:9, out_i = 8:6, out_j = 5:3, out_k = 2:0, out_shift6 = 5:0. out_const18 is {bits 2:0 of the first parcel, the whole second parcel} for a long instruction and 0 for a short one.
- R5: out_class codes: 0 halt (00); 1 branch (01–07); 2 boolean (10–17); 3 shift/mask (20–27, 43); 4 floating add (30–35); 5 integer add (36, 37); 6 multiply/divide (40–42, 44, 45); 7 no-op opcode (46); 8 population count (47); 9 register set (50–77).
- R6: out_nop is 1 exactly for the short parcel octal 46000, or for a long instruction whose first parcel is octal 61000 and whose second parcel is octal 46000.
- R7: A long opcode found in slot 3 is never issued. That slot is discarded, out_valid stays 0, and decoding continues at slot 0 of the next accepted word.
- R8: While out_valid=1 and out_ready=0, all decoded outputs hold their values.
- R9: In a restart cycle out_valid and in_ready are both 0. The unissued remainder of the buffered word is discarded, and the next accepted word starts at slot 0.
- R10: in_ready is 1 when no word is buffered, or when the final instruction of the buffered word is being taken in that cycle; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Branch-taken flush pulse |
| in_valid | input | 1 | Fetch word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| in_word | input | 60 | Packed instruction word |
| out_valid | output | 1 | Decoded instruction offered |
| out_ready | input | 1 | Consumer takes the instruction |
| out_opcode | output | 6 | Two-octal-digit operation code |
| out_i | output | 3 | First register selector |
| out_j | output | 3 | Second register selector |
| out_k | output | 3 | Third register selector |
| out_const18 | output | 18 | Long-form constant, zero for short forms |
| out_shift6 | output | 6 | Shift/mask count field |
| out_long | output | 1 | Instruction is 30 bits |
| out_class | output | 4 | Execution class code |
| out_nop | output | 1 | No-op idiom detected |
| out_slot | output | 2 | Starting parcel position within the word |

## Verification
The bench builds the block with its default of four parcel positions per word, which matches the 60-bit word. With four positions, a long instruction can start in the last legal position (slot 2) and can also appear in the illegal final position (slot 3), so both the straddle case and the skip-to-next-word case are exercised. The same setting also allows a word to hold a mix of short and long instructions, so the issued slot sequence is 0, 1, 3, and in_ready can be seen rising while the final instruction of a word is taken.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam int PARCEL_W = 15;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 3;
    localparam int CONST_W  = 18;
    localparam int SHF_W    = 6;

    typedef enum logic [3:0] {
        CL_HALT   = 4'd0,
        CL_BRANCH = 4'd1,
        CL_BOOL   = 4'd2,
        CL_SHIFT  = 4'd3,
        CL_FADD   = 4'd4,
        CL_IADD   = 4'd5,
        CL_MULDIV = 4'd6,
        CL_NOP    = 4'd7,
        CL_POPCNT = 4'd8,
        CL_SETREG = 4'd9
    } iclass_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [REG_W-1:0]   ri;
        logic [REG_W-1:0]   rj;
        logic [REG_W-1:0]   rk;
        logic [CONST_W-1:0] kconst;
        logic [SHF_W-1:0]   shf;
        logic               is_long;
        iclass_e            cls;
        logic               is_nop;
    } dec_t;

    localparam logic [PARCEL_W-1:0] NOP_SHORT = 15'o46000;
    localparam logic [PARCEL_W-1:0] NOP_LONG0 = 15'o61000;

    // Length rule from the two octal digits of the opcode.
    function automatic logic op_is_long(input logic [OPC_W-1:0] op);
        logic [2:0] hi;
        logic [2:0] lo;
        hi = op[5:3];
        lo = op[2:0];
        if (hi == 3'd0)
            return (lo != 3'd0);
        else if (hi >= 3'd5)
            return (lo <= 3'd2);
        else
            return 1'b0;
    endfunction

    function automatic iclass_e op_class(input logic [OPC_W-1:0] op);
        logic [2:0] hi;
        logic [2:0] lo;
        hi = op[5:3];
        lo = op[2:0];
        case (hi)
            3'd0: return (lo == 3'd0) ? CL_HALT : CL_BRANCH;
            3'd1: return CL_BOOL;
            3'd2: return CL_SHIFT;
            3'd3: return (lo <= 3'd5) ? CL_FADD : CL_IADD;
            3'd4: begin
                case (lo)
                    3'd3:    return CL_SHIFT;
                    3'd6:    return CL_NOP;
                    3'd7:    return CL_POPCNT;
                    default: return CL_MULDIV;
                endcase
            end
            default: return CL_SETREG;
        endcase
    endfunction

endpackage

// File: rtl/pdec_field_decode.sv
module pdec_field_decode
    import pdec_pkg::*;
(
    input  logic [PARCEL_W-1:0] head,
    input  logic [PARCEL_W-1:0] tail,
    output dec_t                dec
);
    logic [OPC_W-1:0] opc;
    logic             lng;

    assign opc = head[PARCEL_W-1 -: OPC_W];
    assign lng = op_is_long(opc);

    always_comb begin
        dec         = '0;
        dec.opcode  = opc;
        dec.ri      = head[3*REG_W-1 -: REG_W];
        dec.rj      = head[2*REG_W-1 -: REG_W];
        dec.rk      = head[REG_W-1:0];
        dec.shf     = head[SHF_W-1:0];
        dec.is_long = lng;
        dec.cls     = op_class(opc);
        dec.kconst  = lng ? {head[REG_W-1:0], tail} : '0;
        dec.is_nop  = lng ? ((head == NOP_LONG0) && (tail == NOP_SHORT))
                          : (head == NOP_SHORT);
    end
endmodule

// File: rtl/pdec_word_buf.sv
module pdec_word_buf
    import pdec_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    parameter int WORD_W = NSLOT * PARCEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    output logic                in_ready,
    input  logic                take,
    input  logic                take_long,
    input  logic                skip,
    output logic                full,
    output logic [SLOT_W-1:0]   ptr,
    output logic [PARCEL_W-1:0] head,
    output logic [PARCEL_W-1:0] tail
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

    logic [WORD_W-1:0]   word_q;
    logic [PARCEL_W-1:0] parcel [NSLOT];
    logic [SLOT_W:0]     next_pos;
    logic                ends_word;
    logic                drain;
    logic                accept;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slice
        assign parcel[s] = word_q[(NSLOT-1-s)*PARCEL_W +: PARCEL_W];
    end

    assign head      = parcel[ptr];
    assign tail      = (ptr == LAST) ? '0 : parcel[ptr + SLOT_W'(1)];
    assign next_pos  = {1'b0, ptr} + (take_long ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1));
    assign ends_word = (next_pos >= (SLOT_W+1)'(NSLOT));
    assign drain     = skip || (take && ends_word);
    assign in_ready  = !restart && (!full || drain);
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (accept) word_q <= in_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ptr  <= '0;
        end else if (restart) begin
            full <= 1'b0;
            ptr  <= '0;
        end else if (accept) begin
            full <= 1'b1;
            ptr  <= '0;
        end else if (skip) begin
            full <= 1'b0;
            ptr  <= '0;
        end else if (take) begin
            if (ends_word) begin
                full <= 1'b0;
                ptr  <= '0;
            end else begin
                ptr <= next_pos[SLOT_W-1:0];
            end
        end
    end

    // R9
    restart_flush_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !full);

    // R2
    fresh_word_top_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (full && ptr == '0));

    // R7
    skip_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (skip && !in_valid && !restart) |=> !full);
endmodule

// File: rtl/parcel_unpacker.sv
module parcel_unpacker
    import pdec_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    parameter int WORD_W = NSLOT * PARCEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OPC_W-1:0]    out_opcode,
    output logic [REG_W-1:0]    out_i,
    output logic [REG_W-1:0]    out_j,
    output logic [REG_W-1:0]    out_k,
    output logic [CONST_W-1:0]  out_const18,
    output logic [SHF_W-1:0]    out_shift6,
    output logic                out_long,
    output logic [3:0]          out_class,
    output logic                out_nop,
    output logic [SLOT_W-1:0]   out_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

    logic                full;
    logic [SLOT_W-1:0]   ptr;
    logic [PARCEL_W-1:0] head;
    logic [PARCEL_W-1:0] tail;
    logic                skip;
    logic                take;
    dec_t                dec;

    pdec_word_buf #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_ready  (in_ready),
        .take      (take),
        .take_long (dec.is_long),
        .skip      (skip),
        .full      (full),
        .ptr       (ptr),
        .head      (head),
        .tail      (tail)
    );

    pdec_field_decode u_dec (
        .head (head),
        .tail (tail),
        .dec  (dec)
    );

    assign skip      = full && dec.is_long && (ptr == LAST) && !restart;
    assign out_valid = full && !skip && !restart;
    assign take      = out_valid && out_ready;

    assign out_opcode  = dec.opcode;
    assign out_i       = dec.ri;
    assign out_j       = dec.rj;
    assign out_k       = dec.rk;
    assign out_const18 = dec.kconst;
    assign out_shift6  = dec.shf;
    assign out_long    = dec.is_long;
    assign out_class   = dec.cls;
    assign out_nop     = dec.is_nop;
    assign out_slot    = ptr;

    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> restart ||
            (out_valid && $stable(out_opcode) && $stable(out_const18) && $stable(out_slot)));

    // R7
    no_straddle_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_long) |-> (out_slot != LAST));

    // R6
    nop_class_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nop) |-> (out_class == CL_NOP || out_class == CL_SETREG));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready));
endmodule

// File: tb/parcel_unpacker_bench.sv
`timescale 1ns/1ps
module parcel_unpacker_bench;
    import pdec_pkg::*;

    localparam int NSLOT = 4;
    localparam int WW    = NSLOT * PARCEL_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          restart = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_word = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [5:0]    out_opcode;
    logic [2:0]    out_i, out_j, out_k;
    logic [17:0]   out_const18;
    logic [5:0]    out_shift6;
    logic          out_long;
    logic [3:0]    out_class;
    logic          out_nop;
    logic [1:0]    out_slot;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    parcel_unpacker #(.NSLOT(NSLOT)) u_parcel_unpacker (
        .clk(clk), .rst(rst), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_i(out_i), .out_j(out_j), .out_k(out_k),
        .out_const18(out_const18), .out_shift6(out_shift6), .out_long(out_long),
        .out_class(out_class), .out_nop(out_nop), .out_slot(out_slot)
    );

    typedef struct packed {
        logic [14:0] p0;
        logic [14:0] p1;
        logic        lng;
        logic [3:0]  cls;
        logic        nop;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{15'o00000, 15'o46000, 1'b0, 4'd0, 1'b0},
        '{15'o01123, 15'o45670, 1'b1, 4'd1, 1'b0},
        '{15'o07456, 15'o12345, 1'b1, 4'd1, 1'b0},
        '{15'o11234, 15'o00000, 1'b0, 4'd2, 1'b0},
        '{15'o20765, 15'o00000, 1'b0, 4'd3, 1'b0},
        '{15'o43012, 15'o00000, 1'b0, 4'd3, 1'b0},
        '{15'o30123, 15'o00000, 1'b0, 4'd4, 1'b0},
        '{15'o37777, 15'o00000, 1'b0, 4'd5, 1'b0},
        '{15'o44555, 15'o00000, 1'b0, 4'd6, 1'b0},
        '{15'o46000, 15'o00000, 1'b0, 4'd7, 1'b1},
        '{15'o46123, 15'o00000, 1'b0, 4'd7, 1'b0},
        '{15'o47010, 15'o00000, 1'b0, 4'd8, 1'b0},
        '{15'o52123, 15'o11111, 1'b1, 4'd9, 1'b0},
        '{15'o53123, 15'o00000, 1'b0, 4'd9, 1'b0},
        '{15'o61000, 15'o46000, 1'b1, 4'd9, 1'b1},
        '{15'o61000, 15'o46001, 1'b1, 4'd9, 1'b0},
        '{15'o73000, 15'o00000, 1'b0, 4'd9, 1'b0},
        '{15'o72000, 15'o00000, 1'b1, 4'd9, 1'b0}
    };

    // captured outputs of the most recent pop
    logic        c_got;
    logic [5:0]  c_op;
    logic [8:0]  c_ijk;
    logic [17:0] c_k18;
    logic [5:0]  c_sh;
    logic        c_lng;
    logic [3:0]  c_cls;
    logic        c_nop;
    logic [1:0]  c_slot;
    logic        c_inrdy;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [WW-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic pop();
        int n;
        n = 0;
        c_got = 1'b0;
        @(negedge clk);
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (out_valid) begin
            c_got = 1'b1;
            out_ready = 1'b1;
            #0.1;
            c_inrdy = in_ready;
            c_op    = out_opcode;
            c_ijk   = {out_i, out_j, out_k};
            c_k18   = out_const18;
            c_sh    = out_shift6;
            c_lng   = out_long;
            c_cls   = out_class;
            c_nop   = out_nop;
            c_slot  = out_slot;
            @(posedge clk);
            #1;
            out_ready = 1'b0;
        end
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(posedge clk);
        #1;
        restart = 1'b0;
    endtask

    initial begin
        #(5.0 * 50000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [17:0] ek;
        logic [5:0]  h_op;
        logic [17:0] h_k;
        logic [1:0]  h_slot;
        logic        h_ok;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 in_ready after reset", in_ready, 1);

        // vector table: decode of the first instruction of a word
        for (int v = 0; v < NV; v++) begin
            push({VEC[v].p0, VEC[v].p1, 15'o46000, 15'o46000});
            pop();
            chk("R2 instruction issued", c_got, 1);
            chk("R2 first slot", c_slot, 0);
            chk("R4 opcode", c_op, VEC[v].p0[14:9]);
            chk("R4 ijk", c_ijk, VEC[v].p0[8:0]);
            chk("R4 shift6", c_sh, VEC[v].p0[5:0]);
            ek = VEC[v].lng ? {VEC[v].p0[2:0], VEC[v].p1} : 18'd0;
            chk("R4 const18", c_k18, ek);
            chk("R3 length", c_lng, VEC[v].lng);
            chk("R5 class", c_cls, VEC[v].cls);
            chk("R6 nop flag", c_nop, VEC[v].nop);
            pulse_restart();
        end

        // mixed word: short, long, short -> slots 0,1,3
        push({15'o11234, 15'o50123, 15'o12345, 15'o36012});
        pop();
        chk("R2 mixed slot a", c_slot, 0);
        chk("R10 in_ready low mid-word", c_inrdy, 0);
        pop();
        chk("R3 mixed slot b", c_slot, 1);
        chk("R3 mixed long const", c_k18, 18'o312345);
        pop();
        chk("R3 mixed slot c after long", c_slot, 3);
        chk("R2 mixed opcode c", c_op, 6'o36);
        chk("R10 in_ready high on final take", c_inrdy, 1);

        // long in slot 2 is legal; uses slot 3 as tail
        push({15'o11000, 15'o12000, 15'o60345, 15'o54321});
        pop();
        pop();
        pop();
        chk("R7 long in slot 2 issued", c_slot, 2);
        chk("R4 long in slot 2 const", c_k18, 18'o554321);

        // long opcode in slot 3 is skipped
        push({15'o11000, 15'o12000, 15'o13000, 15'o51777});
        pop();
        pop();
        pop();
        chk("R7 third short slot", c_slot, 2);
        @(negedge clk);
        chk("R7 skipped slot not issued", out_valid, 0);
        chk("R7 in_ready on skip", in_ready, 1);
        push({15'o14777, 15'o46000, 15'o46000, 15'o46000});
        pop();
        chk("R7 next word slot", c_slot, 0);
        chk("R7 next word opcode", c_op, 6'o14);
        pulse_restart();

        // hold under backpressure
        push({15'o70123, 15'o23456, 15'o46000, 15'o46000});
        @(negedge clk);
        h_op = out_opcode; h_k = out_const18; h_slot = out_slot;
        h_ok = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (!out_valid || out_opcode !== h_op || out_const18 !== h_k || out_slot !== h_slot)
                h_ok = 1'b0;
        end
        chk("R8 outputs held while stalled", h_ok, 1);
        chk("R8 held const", out_const18, 18'o323456);
        pulse_restart();

        // restart flushes remainder
        push({15'o11234, 15'o22345, 15'o33456, 15'o47012});
        pop();
        @(negedge clk);
        restart = 1'b1;
        #0.1;
        chk("R9 out_valid low during restart", out_valid, 0);
        chk("R9 in_ready low during restart", in_ready, 0);
        @(posedge clk);
        #1;
        restart = 1'b0;
        @(negedge clk);
        chk("R9 remainder dropped", out_valid, 0);
        push({15'o47012, 15'o11111, 15'o46000, 15'o46000});
        pop();
        chk("R9 target slot", c_slot, 0);
        chk("R9 target opcode", c_op, 6'o47);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule